// File: doc/BRIEF.md
# Sequential Stream Memory Controller for a Hardware Loop Body

This block moves data between memory and a hardware loop datapath. It handles loops that have been moved out of software into logic. Software programs a start address, an iteration count and the transfer options through four word registers, then sets an enable bit. The controller then walks memory one word at a time, either upward or downward. In read streams it forwards each fetched word to the datapath. In write streams it stores each word the datapath offers.

Two pacing modes exist. In block mode a transfer is attempted on every clock for as long as memory and data allow. In single mode each transfer waits for a step pulse from the datapath. When the programmed count runs out, the controller raises a sticky completion flag, which drives an interrupt line. The processor can sleep during the loop and be woken by that line. Software clears the flag by writing 1 to it.

Top module: `loop_stream_dma`

## Requirements
- R1: After reset, `irq`, `mem_req` and `lp_rd_valid` are low, and the status register (select 3) reads 0.
- R2: A write to the control register (select 2) with bit 0 set starts a run when the block is idle and the stored length (select 1) is non-zero. The first request carries the stored start address (select 0).
- R3: In block mode (control bit 3 = 1) with `mem_ready` held high, one transfer is accepted per clock. With control bit 1 = 0, successive addresses rise by 4. Exactly the programmed count of transfers takes place.
- R4: With control bit 1 = 1, successive addresses fall by 4.
- R5: In a write stream (control bit 2 = 1), a request is raised only while `lp_wr_valid` is high. It carries `lp_wr_data` with `mem_we` high, and `lp_wr_ready` marks the accepted word.
- R6: In single mode (control bit 3 = 0), no request is made until a `lp_step` pulse arrives. Each pulse yields exactly one transfer.
- R7: While `mem_req` is high and `mem_ready` is low, the address and the remaining count hold their values.
- R8: The transfer that uses up the count sets the done flag, status bit 1, which drives `irq`. The flag stays set until software writes 1 to status bit 1. A clear that lands in the same cycle as completion loses, and the flag remains set.
- R9: Starting with a length of 0 sets done on the next cycle and makes no memory request.
- R10: While busy, writes to the length register and to the control register are ignored, and that includes a new enable.
- R11: The status register reports busy in bit 0, done in bit 1 and the remaining count in bits 31:16.
- R12: For a read stream, `lp_rd_valid` is high in the cycle after each accepted read, with `lp_rd_data` equal to the word memory returns for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 start address, 1 length, 2 control, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DATA_W | Read data, valid the cycle after an accepted read |
| lp_rd_valid | output | 1 | Read word delivered to the datapath |
| lp_rd_data | output | DATA_W | Read word for the datapath |
| lp_wr_valid | input | 1 | Datapath offers a result word |
| lp_wr_data | input | DATA_W | Result word from the datapath |
| lp_wr_ready | output | 1 | Result word accepted |
| lp_step | input | 1 | Single-mode transfer request pulse |
| irq | output | 1 | Completion interrupt (done flag) |

## Verification
Completion of the final transfer and the software write that clears the done flag can occur on the same clock edge. The bench sets this up by stalling a one-word run with `mem_ready` low. It then releases memory in the same cycle that it writes the clear bit. It judges the outcome by requiring `irq` to stay high afterwards and to drop only after a second clear. A stall that coincides with a register write is also provoked. Length and control writes during a stalled run are shown to leave the readback, the remaining count and the stepping direction unchanged.

// File: rtl/loop_stream_dma.sv
module loop_stream_dma #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              lp_rd_valid,
  output logic [DATA_W-1:0] lp_rd_data,
  input  logic              lp_wr_valid,
  input  logic [DATA_W-1:0] lp_wr_data,
  output logic              lp_wr_ready,
  input  logic              lp_step,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  localparam logic [LEN_W-1:0]  ONE  = LEN_W'(1);
  localparam logic [1:0] SEL_BASE = 2'd0, SEL_LEN = 2'd1, SEL_CTRL = 2'd2, SEL_STAT = 2'd3;

  logic [ADDR_W-1:0] base_q, addr_q;
  logic [LEN_W-1:0]  len_q, rem_q;
  logic dir_q, wr_q, blk_q, busy_q, done_q, pend_q, rdv_q;

  wire idle_wr = reg_we & ~busy_q;
  wire start   = idle_wr & (reg_sel == SEL_CTRL) & reg_wdata[0];
  wire clr     = reg_we & (reg_sel == SEL_STAT) & reg_wdata[1];
  wire gate    = wr_q ? lp_wr_valid : 1'b1;
  wire accept  = mem_req & mem_ready;
  wire last    = accept & (rem_q == ONE);

  assign mem_req     = busy_q & gate & (blk_q | pend_q);
  assign mem_we      = wr_q;
  assign mem_addr    = addr_q;
  assign mem_wdata   = lp_wr_data;
  assign lp_wr_ready = accept & wr_q;
  assign lp_rd_valid = rdv_q;
  assign lp_rd_data  = mem_rdata;
  assign irq         = done_q;

  always_comb begin
    case (reg_sel)
      SEL_BASE: reg_rdata = 32'(base_q);
      SEL_LEN:  reg_rdata = 32'(len_q);
      SEL_CTRL: reg_rdata = {28'd0, blk_q, wr_q, dir_q, busy_q};
      default:  reg_rdata = (32'(rem_q) << 16) | {30'd0, done_q, busy_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      dir_q  <= 1'b0;
      wr_q   <= 1'b0;
      blk_q  <= 1'b0;
    end else if (idle_wr) begin
      if (reg_sel == SEL_BASE) base_q <= reg_wdata[ADDR_W-1:0];
      if (reg_sel == SEL_LEN)  len_q  <= reg_wdata[LEN_W-1:0];
      if (reg_sel == SEL_CTRL) begin
        dir_q <= reg_wdata[1];
        wr_q  <= reg_wdata[2];
        blk_q <= reg_wdata[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      pend_q <= 1'b0;
      rdv_q  <= 1'b0;
    end else begin
      rdv_q <= accept & ~wr_q;
      if (start) begin
        busy_q <= (len_q != '0);
        done_q <= (len_q == '0);
        addr_q <= base_q;
        rem_q  <= len_q;
        pend_q <= 1'b0;
      end else begin
        if (last) busy_q <= 1'b0;
        if (last) done_q <= 1'b1;
        else if (clr) done_q <= 1'b0;
        if (accept) begin
          addr_q <= dir_q ? addr_q - STEP : addr_q + STEP;
          rem_q  <= rem_q - ONE;
        end
        if (lp_step & busy_q & ~blk_q) pend_q <= 1'b1;
        else if (accept) pend_q <= 1'b0;
      end
    end
  end

  a_r3_block_step: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q & accept & ~last) |=>
      (mem_addr == ($past(dir_q) ? $past(mem_addr) - STEP : $past(mem_addr) + STEP)));

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req & ~mem_ready & ~start) |=> ($stable(mem_addr) && $stable(rem_q)));

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~clr & ~start) |=> irq);

  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start & (len_q == '0)) |=> (irq && !mem_req));

  a_r10_len_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(len_q));

  a_r6_single_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (~blk_q & accept) |=> (!mem_req || $past(lp_step)));

  a_r12_read_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (accept & ~mem_we) |=> lp_rd_valid);
endmodule

// File: tb/loop_stream_dma_tb_top.sv
`timescale 1ns/1ps
module loop_stream_dma_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, lp_rd_data;
  logic lp_rd_valid, lp_wr_ready, irq;
  logic lp_wr_valid = 1'b0, lp_step = 1'b0;
  logic [31:0] lp_wr_data = '0;
  logic [31:0] rdq;
  int checks = 0, fails = 0;

  localparam logic [31:0] KEY = 32'hA5A5_0000;
  localparam logic [40:0] VEC [4] = '{
    {32'h0000_1000, 8'd5, 1'b0},
    {32'h0000_2040, 8'd4, 1'b1},
    {32'h0000_0300, 8'd1, 1'b0},
    {32'h0000_0010, 8'd3, 1'b1}
  };

  always #4 clk = ~clk;

  always_ff @(posedge clk)
    if (mem_req && mem_ready && !mem_we) rdq <= mem_addr ^ KEY;
  assign mem_rdata = rdq;

  loop_stream_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .lp_rd_valid(lp_rd_valid),
    .lp_rd_data(lp_rd_data), .lp_wr_valid(lp_wr_valid), .lp_wr_data(lp_wr_data),
    .lp_wr_ready(lp_wr_ready), .lp_step(lp_step), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'd0;
    #1;
  endtask

  task automatic rreg(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
    reg_sel = 2'd0;
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    while (!irq && cyc < 200) begin
      @(negedge clk); #1; cyc++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, exp, pa;
    int n, cyc;
    bit pend, dir;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!irq && !mem_req && !lp_rd_valid, "R1 outputs idle", {irq, mem_req, lp_rd_valid}, 0);
    rreg(2'd3, d);
    chk(d == 0, "R1 status", d, 0);

    // R2 R3 R4 R12: table of block-mode read runs
    foreach (VEC[i]) begin
      dir = VEC[i][0];
      wreg(2'd0, VEC[i][40:9]);
      wreg(2'd1, 32'(VEC[i][8:1]));
      wreg(2'd2, dir ? 32'hB : 32'h9);
      exp = VEC[i][40:9]; n = 0; pend = 0; cyc = 0;
      while (cyc < 100) begin
        if (pend) chk(lp_rd_valid && lp_rd_data == (pa ^ KEY), "R12 read forward", lp_rd_data, pa ^ KEY);
        if (irq) break;
        if (mem_req) begin
          chk(mem_addr == exp, n == 0 ? "R2 first address" : (dir ? "R4 down step" : "R3 up step"), mem_addr, exp);
          pa = mem_addr; pend = 1;
          exp = dir ? exp - 4 : exp + 4;
          n++;
        end else pend = 0;
        @(negedge clk); #1; cyc++;
      end
      chk(n == int'(VEC[i][8:1]), "R3 transfer count", n, VEC[i][8:1]);
      chk(cyc == int'(VEC[i][8:1]), "R3 one per cycle", cyc, VEC[i][8:1]);
      rreg(2'd3, d);
      chk(d == 32'h2, "R11 status after run", d, 32'h2);
      wreg(2'd3, 32'h2);
      chk(!irq, "R8 clear", irq, 0);
    end

    // R5 write stream, paced by datapath valid
    wreg(2'd0, 32'h400);
    wreg(2'd1, 32'd3);
    wreg(2'd2, 32'hD);
    chk(!mem_req, "R5 waits for data", mem_req, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      lp_wr_valid = 1'b1; lp_wr_data = 32'hC0DE_0000 + k;
      #1;
      chk(mem_req && mem_we && lp_wr_ready && mem_addr == 32'h400 + 4*k && mem_wdata == 32'hC0DE_0000 + k,
          "R5 write beat", mem_addr, 32'h400 + 4*k);
      @(negedge clk);
      lp_wr_valid = 1'b0;
      #1;
    end
    chk(irq, "R8 done after write run", irq, 1);
    wreg(2'd3, 32'h2);

    // R6 single mode
    wreg(2'd0, 32'h800);
    wreg(2'd1, 32'd2);
    wreg(2'd2, 32'h1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(!mem_req, "R6 no request without step", mem_req, 0);
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); lp_step = 1'b1;
      @(negedge clk); lp_step = 1'b0; #1;
      chk(mem_req && mem_addr == 32'h800 + 4*k, "R6 one transfer per step", mem_addr, 32'h800 + 4*k);
      @(negedge clk); #1;
      chk(!mem_req, "R6 single transfer only", mem_req, 0);
      if (k == 0) begin
        rreg(2'd3, d);
        chk(d == 32'h0001_0001, "R11 remaining in single mode", d, 32'h0001_0001);
      end
    end
    chk(irq, "R8 done after single run", irq, 1);
    wreg(2'd3, 32'h2);

    // R7 R10 stall while busy, with ignored writes
    mem_ready = 1'b0;
    wreg(2'd0, 32'h100);
    wreg(2'd1, 32'd4);
    wreg(2'd2, 32'h9);
    wreg(2'd1, 32'd7);
    wreg(2'd2, 32'hB);
    rreg(2'd1, d);
    chk(d == 32'd4, "R10 length write ignored", d, 32'd4);
    rreg(2'd3, d);
    chk(d == 32'h0004_0001, "R7 count held in stall", d, 32'h0004_0001);
    chk(mem_req && mem_addr == 32'h100, "R7 address held in stall", mem_addr, 32'h100);
    mem_ready = 1'b1;
    @(negedge clk); #1;
    chk(mem_addr == 32'h104, "R10 direction unchanged", mem_addr, 32'h104);
    mem_ready = 1'b0;
    @(negedge clk); #1;
    chk(mem_addr == 32'h104, "R7 address held again", mem_addr, 32'h104);
    mem_ready = 1'b1;
    wait_irq(cyc);
    chk(cyc == 3, "R3 remaining transfers after stall", cyc, 3);
    wreg(2'd3, 32'h2);

    // R9 zero length
    wreg(2'd1, 32'd0);
    wreg(2'd2, 32'h9);
    chk(irq && !mem_req, "R9 zero length done", {irq, mem_req}, 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(irq && !mem_req, "R8 sticky, R9 no access", {irq, mem_req}, 2);
    end
    wreg(2'd3, 32'h2);

    // R8 completion and clear in the same cycle
    wreg(2'd0, 32'h200);
    wreg(2'd1, 32'd1);
    mem_ready = 1'b0;
    wreg(2'd2, 32'h9);
    @(negedge clk);
    mem_ready = 1'b1;
    reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h2;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'd0;
    #1;
    chk(irq, "R8 completion beats clear", irq, 1);
    wreg(2'd3, 32'h2);
    chk(!irq, "R8 later clear works", irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule